// File: doc/BRIEF.md
# Serial Receiver with Deferred Error Status

This block recovers asynchronous serial characters from a single receive line. A tick at sixteen times the bit rate paces it. It accepts characters of five to eight data bits and checks an optional parity bit, which may be even, odd or forced to a fixed level. It samples one stop bit and recognises a break, meaning the line held low for a whole frame. Each character becomes a 12-bit entry: eight data bits followed by four error flags. The entry is written into a receive queue, or into a single holding slot when queueing is switched off.

Software-side logic pops entries through a read strobe. The head entry, data and flags together, is always visible on the read port. A separate four-bit status word follows the character that was read last: its framing, parity and break bits load only when a read happens. Its overrun bit sets as soon as a character is lost. A clear strobe empties the status word. Empty and full flags describe the queue or the holding slot. A request-to-send output can follow the free space for hardware flow control.

Top module: `uart_rx_capture`

## Requirements
- R1: After reset the status word is 0, `rx_empty` is 1 and `rx_full` is 0.
- R2: Data is received LSB first. `word_len` selects the data width: 0=5, 1=6, 2=7, 3=8 bits. Entry bits [7:0] hold the data with its unused upper bits at 0, bit 8 framing error, bit 9 parity error, bit 10 break, bit 11 overrun.
- R3: A falling edge starts a character only if the line is still low at the middle of the start bit. A low pulse of a quarter bit produces no entry.
- R4: With `parity_en` set, a parity bit follows the data. `even_par`=1 expects an even count of ones over data and parity, and `even_par`=0 expects an odd count. With `stick_par`=1 the parity bit is expected to be the inverse of `even_par`. A mismatch sets entry bit 9.
- R5: A single stop bit is sampled. If it is low, entry bit 8 is set. A new start bit directly after one stop bit is received as the next character.
- R6: A frame that is low from the start bit through the stop bit yields data 0 with bits 8 and 10 set and bit 9 clear. No further character starts until the line has returned high.
- R7: With `fifo_en`=1 the queue holds DEPTH entries and returns them in arrival order, and `rx_full` rises when DEPTH are stored. With `fifo_en`=0 the holding slot keeps one entry, and `rx_full` rises when it holds one.
- R8: Status bit 0 is framing, bit 1 parity, bit 2 break, bit 3 overrun. Bits 0 to 2 take the flags of the entry popped by `rd_pop` in the cycle after the pop, and they do not change without a pop.
- R9: A character that completes while the store is full and no pop occurs is discarded. It sets bit 11 on the newest stored entry, and it sets status bit 3 in the next cycle without any read. Status bit 3 stays set until cleared.
- R10: An `err_clr` pulse clears all four status bits in the next cycle. If an overrun happens in the same cycle, status bit 3 ends up set.
- R11: A pop in the same cycle that a character completes into a full store frees the space: the character is stored and no overrun is recorded.
- R12: With `rts_flow_en`=1, `rts_out` is 1 exactly while the store has room. With `rts_flow_en`=0 it follows `rts_manual`.
- R13: Clearing `rx_en` or `uart_en` during a character lets that character complete. No new character starts while either enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| uart_en | input | 1 | Global enable |
| rx_en | input | 1 | Receiver enable |
| fifo_en | input | 1 | 1: queue of DEPTH entries, 0: single holding slot |
| word_len | input | 2 | Data width code (0..3 = 5..8 bits) |
| parity_en | input | 1 | Parity bit present |
| even_par | input | 1 | Even (1) or odd (0) parity |
| stick_par | input | 1 | Fixed-level parity |
| rts_flow_en | input | 1 | Request-to-send follows free space |
| rts_manual | input | 1 | Request-to-send level when flow control is off |
| rd_pop | input | 1 | Pop the head entry |
| err_clr | input | 1 | Clear the status word |
| rd_entry | output | 12 | Head entry (0 when empty) |
| rx_status | output | 4 | Status word |
| rx_empty | output | 1 | Store empty |
| rx_full | output | 1 | Store full |
| rts_out | output | 1 | Request to send, active high |

## Verification
Two pairs of actions can fall in the same clock: a character completing while a read pops a full store, and a character overrunning while the status clear is strobed. The bench drives the 16x tick itself, so it knows which tick samples the stop bit. It places the read or clear strobe on exactly that clock. The pop must make room, so the new character is stored and status bit 3 stays 0. The overrun must outlive the clear, so status bit 3 reads 1 after the clock.

// File: rtl/rxc_pkg.sv
`timescale 1ns/1ps
package rxc_pkg;
    localparam int ENTRY_W = 12;
    localparam int STAT_W  = 4;

    typedef struct packed {
        logic       ovr;
        logic       brk;
        logic       par;
        logic       frm;
        logic [7:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       even;
        logic       stick;
    } rx_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP,
        PH_WAIT_HIGH
    } rx_phase_e;
endpackage

// File: rtl/rxc_sync.sv
`timescale 1ns/1ps
module rxc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/rxc_deser.sv
`timescale 1ns/1ps
module rxc_deser
    import rxc_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd_s,
    input  logic      start_ok,
    input  rx_cfg_t   cfg_in,
    output logic      push_valid,
    output rx_entry_t push_entry
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 2);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);

    typedef struct packed {
        rx_phase_e        phase;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       idx;
        logic [7:0]       shreg;
        logic             pbit;
        logic             all_low;
        rx_cfg_t          cfg;
    } deser_st_t;

    deser_st_t st_d, st_q;
    logic [2:0] last_idx;
    logic       exp_par;
    logic       is_brk;

    always_comb begin
        st_d       = st_q;
        push_valid = 1'b0;
        push_entry = '0;
        last_idx   = 3'd4 + {1'b0, st_q.cfg.wlen};
        exp_par    = st_q.cfg.stick ? ~st_q.cfg.even : ((^st_q.shreg) ^ ~st_q.cfg.even);
        is_brk     = st_q.all_low && !rxd_s;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (tick && !rxd_s && start_ok) begin
                    st_d.phase   = PH_START;
                    st_d.cnt     = '0;
                    st_d.idx     = '0;
                    st_d.shreg   = '0;
                    st_d.pbit    = 1'b0;
                    st_d.all_low = 1'b1;
                    st_d.cfg     = cfg_in;
                end
            end
            PH_START: begin
                if (tick) begin
                    if (st_q.cnt == MID_CNT) begin
                        st_d.cnt   = '0;
                        st_d.phase = rxd_s ? PH_IDLE : PH_DATA;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (tick) begin
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.cnt               = '0;
                        st_d.shreg[st_q.idx]   = rxd_s;
                        st_d.all_low           = st_q.all_low && !rxd_s;
                        if (st_q.idx == last_idx)
                            st_d.phase = st_q.cfg.par_en ? PH_PAR : PH_STOP;
                        else
                            st_d.idx = st_q.idx + 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_PAR: begin
                if (tick) begin
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.cnt     = '0;
                        st_d.pbit    = rxd_s;
                        st_d.all_low = st_q.all_low && !rxd_s;
                        st_d.phase   = PH_STOP;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_STOP: begin
                if (tick) begin
                    if (st_q.cnt == LAST_CNT) begin
                        push_valid      = 1'b1;
                        push_entry.data = is_brk ? 8'h00 : st_q.shreg;
                        push_entry.frm  = !rxd_s;
                        push_entry.brk  = is_brk;
                        push_entry.par  = st_q.cfg.par_en && !is_brk && (st_q.pbit != exp_par);
                        push_entry.ovr  = 1'b0;
                        st_d.cnt        = '0;
                        st_d.phase      = rxd_s ? PH_IDLE : PH_WAIT_HIGH;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_WAIT_HIGH: begin
                if (rxd_s) st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid); // R2
    AST_BREAK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_entry.brk) |-> (push_entry.frm && !push_entry.par && push_entry.data == 8'h00)); // R6
    AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> (st_q.phase == PH_IDLE || st_q.phase == PH_WAIT_HIGH)); // R6
endmodule

// File: rtl/rxc_fifo.sv
`timescale 1ns/1ps
module rxc_fifo
    import rxc_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fifo_mode,
    input  logic      push,
    input  rx_entry_t push_data,
    input  logic      pop_req,
    output logic      pop_done,
    output logic      ovr_evt,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][ENTRY_W-1:0] mem;
        logic [PTR_W-1:0]              wr;
        logic [PTR_W-1:0]              rd;
        logic [CNT_W-1:0]              cnt;
    } fifo_st_t;

    fifo_st_t         st_d, st_q;
    logic [CNT_W-1:0] cap;
    logic [PTR_W-1:0] newest;
    logic             room;

    always_comb begin
        st_d     = st_q;
        ovr_evt  = 1'b0;
        cap      = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
        pop_done = pop_req && (st_q.cnt != '0);
        room     = (st_q.cnt < cap) || pop_done;
        newest   = (st_q.wr == '0) ? PTR_LAST : st_q.wr - 1'b1;

        if (pop_done)
            st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + 1'b1;

        if (push && room) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + 1'b1;
        end else if (push) begin
            ovr_evt = 1'b1;
            st_d.mem[newest][ENTRY_W-1] = 1'b1;
        end

        unique case ({push && room, pop_done})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = (st_q.cnt != '0) ? rx_entry_t'(st_q.mem[st_q.rd]) : '0;
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt >= cap);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop_req) |=> $stable(st_q.cnt)); // R7
    AST_NO_DROP_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop_done) |-> !ovr_evt); // R11
endmodule

// File: rtl/rxc_status.sv
`timescale 1ns/1ps
module rxc_status
    import rxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  rx_entry_t         popped,
    input  logic              ovr_evt,
    input  logic              clr,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (pop) begin
            stat_d[0] = popped.frm;
            stat_d[1] = popped.par;
            stat_d[2] = popped.brk;
            stat_d[3] = stat_q[3] | popped.ovr;
        end
        if (clr)     stat_d    = '0;
        if (ovr_evt) stat_d[3] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop && !clr) |=> $stable(stat_q[2:0])); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[3] && !clr) |=> stat_q[3]); // R9
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ovr_evt) |=> (stat_q == '0)); // R10
    AST_OVR_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> stat_q[3]); // R10
endmodule

// File: rtl/uart_rx_capture.sv
`timescale 1ns/1ps
module uart_rx_capture
    import rxc_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_tick16,
    input  logic        rxd,
    input  logic        uart_en,
    input  logic        rx_en,
    input  logic        fifo_en,
    input  logic [1:0]  word_len,
    input  logic        parity_en,
    input  logic        even_par,
    input  logic        stick_par,
    input  logic        rts_flow_en,
    input  logic        rts_manual,
    input  logic        rd_pop,
    input  logic        err_clr,
    output logic [11:0] rd_entry,
    output logic [3:0]  rx_status,
    output logic        rx_empty,
    output logic        rx_full,
    output logic        rts_out
);
    logic      rxd_s;
    logic      push_valid;
    rx_entry_t push_entry;
    rx_entry_t head;
    rx_cfg_t   cfg;
    logic      pop_done;
    logic      ovr_evt;

    always_comb begin
        cfg.wlen   = word_len;
        cfg.par_en = parity_en;
        cfg.even   = even_par;
        cfg.stick  = stick_par;
    end

    rxc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    rxc_deser #(.OVERSAMPLE(OVERSAMPLE)) i_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick16),
        .rxd_s     (rxd_s),
        .start_ok  (uart_en && rx_en),
        .cfg_in    (cfg),
        .push_valid(push_valid),
        .push_entry(push_entry)
    );

    rxc_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_mode(fifo_en),
        .push     (push_valid),
        .push_data(push_entry),
        .pop_req  (rd_pop),
        .pop_done (pop_done),
        .ovr_evt  (ovr_evt),
        .head     (head),
        .empty    (rx_empty),
        .full     (rx_full)
    );

    rxc_status i_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop    (pop_done),
        .popped (head),
        .ovr_evt(ovr_evt),
        .clr    (err_clr),
        .stat   (rx_status)
    );

    assign rd_entry = head;
    assign rts_out  = rts_flow_en ? !rx_full : rts_manual;

    AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |-> (rx_full && !rd_pop)); // R9
    AST_OVR_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> rx_status[3]); // R9
    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && !push_valid) |=> rx_empty); // R7
endmodule

// File: tb/test_uart_rx_capture.sv
`timescale 1ns/1ps
module test_uart_rx_capture;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick16 = 1'b0;
    logic        rxd = 1'b1;
    logic        uart_en = 1'b1;
    logic        rx_en = 1'b1;
    logic        fifo_en = 1'b1;
    logic [1:0]  word_len = 2'd3;
    logic        parity_en = 1'b0;
    logic        even_par = 1'b0;
    logic        stick_par = 1'b0;
    logic        rts_flow_en = 1'b1;
    logic        rts_manual = 1'b0;
    logic        rd_pop = 1'b0;
    logic        err_clr = 1'b0;
    logic [11:0] rd_entry;
    logic [3:0]  rx_status;
    logic        rx_empty;
    logic        rx_full;
    logic        rts_out;

    int checks = 0;
    int failures = 0;
    logic [11:0] cap_entry;

    uart_rx_capture #(.DEPTH(DEPTH)) i_uart_rx_capture (
        .clk(clk), .rst_n(rst_n), .baud_tick16(baud_tick16), .rxd(rxd),
        .uart_en(uart_en), .rx_en(rx_en), .fifo_en(fifo_en), .word_len(word_len),
        .parity_en(parity_en), .even_par(even_par), .stick_par(stick_par),
        .rts_flow_en(rts_flow_en), .rts_manual(rts_manual), .rd_pop(rd_pop),
        .err_clr(err_clr), .rd_entry(rd_entry), .rx_status(rx_status),
        .rx_empty(rx_empty), .rx_full(rx_full), .rts_out(rts_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick_once(input bit rd_here, input bit clr_here);
        @(negedge clk);
        baud_tick16 = 1'b1;
        rd_pop = rd_here;
        err_clr = clr_here;
        if (rd_here) cap_entry = rd_entry;
        @(negedge clk);
        baud_tick16 = 1'b0;
        rd_pop = 1'b0;
        err_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle_ticks(input logic lvl, input int n);
        rxd = lvl;
        for (int i = 0; i < n; i++) tick_once(1'b0, 1'b0);
    endtask

    function automatic logic par_of(input logic [7:0] d, input int nb);
        logic [7:0] m;
        m = 8'hFF >> (8 - nb);
        if (stick_par) return ~even_par;
        return (^(d & m)) ^ ~even_par;
    endfunction

    // bit 0 = start, 1..nb data, optional parity, then one stop
    task automatic send_frame(input logic [7:0] d, input int nb, input bit has_par, input logic pbit,
                              input logic stop, input bit rd_stop, input bit clr_stop, input int dis_at);
        int nbits;
        nbits = nb + 2 + (has_par ? 1 : 0);
        for (int b = 0; b < nbits; b++) begin
            if (b == 0) rxd = 1'b0;
            else if (b <= nb) rxd = d[b-1];
            else if (has_par && b == nb + 1) rxd = pbit;
            else rxd = stop;
            if (dis_at >= 0 && b == dis_at + 1) rx_en = 1'b0;
            for (int t = 0; t < 16; t++)
                tick_once(rd_stop && b == nbits - 1 && t == 8, clr_stop && b == nbits - 1 && t == 8);
        end
    endtask

    task automatic send_plain(input logic [7:0] d, input int nb);
        send_frame(d, nb, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, -1);
    endtask

    task automatic read_one(output logic [11:0] e);
        @(negedge clk);
        rd_pop = 1'b1;
        e = rd_entry;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", rx_status, 4'h0);
        check("R1 empty", rx_empty, 1'b1);
        check("R1 full", rx_full, 1'b0);
        check("R12 rts with room", rts_out, 1'b1);
    endtask

    task automatic t_basic();
        logic [11:0] e;
        word_len = 2'd3;
        send_plain(8'hA5, 8);
        check("R2 not empty", rx_empty, 1'b0);
        read_one(e);
        check("R2 8-bit entry", e, 12'h0A5);
        check("R2 empty after read", rx_empty, 1'b1);
        word_len = 2'd0;
        send_plain(8'h13, 5);
        read_one(e);
        check("R2 5-bit entry", e, 12'h013);
        word_len = 2'd2;
        send_plain(8'h55, 7);
        read_one(e);
        check("R2 7-bit entry", e, 12'h055);
        word_len = 2'd3;
    endtask

    task automatic t_parity();
        logic [11:0] e;
        parity_en = 1'b1; even_par = 1'b1; stick_par = 1'b0;
        send_frame(8'h3C, 8, 1'b1, par_of(8'h3C, 8), 1'b1, 1'b0, 1'b0, -1);
        read_one(e);
        check("R4 even good", e, 12'h03C);
        send_frame(8'h3C, 8, 1'b1, ~par_of(8'h3C, 8), 1'b1, 1'b0, 1'b0, -1);
        check("R8 status before read", rx_status, 4'h0);
        check("R4 even bad entry", rd_entry, 12'h23C);
        read_one(e);
        check("R8 status after read", rx_status, 4'h2);
        even_par = 1'b0;
        send_frame(8'h07, 8, 1'b1, par_of(8'h07, 8), 1'b1, 1'b0, 1'b0, -1);
        read_one(e);
        check("R4 odd good", e, 12'h007);
        check("R8 status reloaded by clean read", rx_status, 4'h0);
        stick_par = 1'b1;
        send_frame(8'h5A, 8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, -1);
        read_one(e);
        check("R4 stick good", e, 12'h05A);
        send_frame(8'h5A, 8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, -1);
        read_one(e);
        check("R4 stick bad", e, 12'h25A);
        parity_en = 1'b0; stick_par = 1'b0;
        read_one(e);
        check("R8 empty read keeps status", rx_status, 4'h2);
    endtask

    task automatic t_framing();
        logic [11:0] e;
        send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        idle_ticks(1'b1, 16);
        read_one(e);
        check("R5 framing entry", e, 12'h181);
        check("R8 framing status", rx_status, 4'h1);
        send_plain(8'h11, 8);
        send_plain(8'h22, 8);
        read_one(e);
        check("R5 back-to-back first", e, 12'h011);
        read_one(e);
        check("R5 back-to-back second", e, 12'h022);
    endtask

    task automatic t_break();
        logic [11:0] e;
        send_frame(8'h00, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        idle_ticks(1'b0, 48);
        idle_ticks(1'b1, 16);
        read_one(e);
        check("R6 break entry", e, 12'h500);
        check("R6 single entry while low", rx_empty, 1'b1);
        check("R8 break status", rx_status, 4'h5);
    endtask

    task automatic t_glitch();
        idle_ticks(1'b0, 4);
        idle_ticks(1'b1, 40);
        check("R3 glitch rejected", rx_empty, 1'b1);
    endtask

    task automatic t_enable();
        logic [11:0] e;
        send_frame(8'h6E, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2);
        read_one(e);
        check("R13 completes after disable", e, 12'h06E);
        send_plain(8'h77, 8);
        check("R13 no start while disabled", rx_empty, 1'b1);
        rx_en = 1'b1;
    endtask

    task automatic t_fifo();
        logic [11:0] e;
        fifo_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            check("R12 rts before full", rts_out, 1'b1);
            send_plain(8'(i * 7 + 3), 8);
        end
        check("R7 full at depth", rx_full, 1'b1);
        check("R12 rts deasserted", rts_out, 1'b0);
        rts_flow_en = 1'b0; rts_manual = 1'b1;
        @(negedge clk);
        check("R12 manual rts", rts_out, 1'b1);
        rts_flow_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            read_one(e);
            check("R7 order", e, {4'h0, 8'(i * 7 + 3)});
        end
        check("R7 empty after drain", rx_empty, 1'b1);
        check("R12 rts restored", rts_out, 1'b1);
    endtask

    task automatic t_overrun();
        logic [11:0] e;
        fifo_en = 1'b0;
        send_plain(8'h41, 8);
        check("R7 holding full", rx_full, 1'b1);
        check("R12 rts holding full", rts_out, 1'b0);
        send_plain(8'h42, 8);
        check("R9 status set without read", rx_status, 4'h8);
        check("R9 flag on stored entry", rd_entry, 12'h841);
        read_one(e);
        check("R9 read entry", e, 12'h841);
        check("R9 status after read", rx_status, 4'h8);
        check("R9 second discarded", rx_empty, 1'b1);
        pulse_clear();
        check("R10 clear", rx_status, 4'h0);
    endtask

    task automatic t_same_cycle();
        logic [11:0] e;
        fifo_en = 1'b0;
        send_plain(8'h61, 8);
        send_frame(8'h62, 8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, -1);
        check("R11 read value", cap_entry, 12'h061);
        check("R11 new stored", rd_entry, 12'h062);
        check("R11 no overrun", rx_status, 4'h0);
        check("R11 still full", rx_full, 1'b1);
        read_one(e);
        send_plain(8'h63, 8);
        send_frame(8'h64, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, -1);
        check("R10 overrun beats clear", rx_status, 4'h8);
        read_one(e);
        check("R10 entry flagged", e, 12'h863);
        pulse_clear();
        check("R10 final clear", rx_status, 4'h0);
        fifo_en = 1'b1;
    endtask

    initial begin
        #(150000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_parity();
        t_framing();
        t_break();
        t_glitch();
        t_enable();
        t_fifo();
        t_overrun();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule